// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block steers the 6-bit gain code of an input amplifier from the size of the signed samples that come back from the converter. The gain code covers -12 dB to +35.25 dB in 0.75 dB steps, so code 16 is 0 dB. Each valid sample is compared with a programmable target level. Loud samples start an attack that lowers the gain. Once the signal is quiet again, a hold time runs out and then a decay raises the gain step by step. Every timer counts a shared slow tick. Each rate or hold code doubles its base period once per increment.

A mode input selects between two behaviours. In level tracking, attack steps are paced by the attack timer. In peak limiting, every sample above target removes one step at once and the hold is skipped. A noise gate can block gain increases while the signal stays under a small threshold. An optional zero-cross setting holds any step back until a sample arrives whose sign differs from the one before. Gain steps only ever take effect on a valid sample. The result is clamped into a window chosen by two 3-bit codes. While the block is disabled, the gain output follows a manual value.

Top module: `alc_gain_engine`

## Requirements
- R1: While `en_i` is 0, `gain_o` equals `manual_gain_i` and `limit_o` is 0. The internal gain is loaded from `manual_gain_i`, so re-enabling starts from that value. The timer returns to decay with a cleared count and no pending step.
- R2: After reset, the gain code is 16, both flags are 0 and the timer is in decay.
- R3: A valid sample whose magnitude exceeds (target_i+1)*2^(SW-5) enters attack. In level-tracking mode (`limiter_i`=0), attack lowers the gain by one code every ATK_BASE<<attack_i ticks while it lasts.
- R4: When a valid sample at or below target ends an attack in level-tracking mode, gain increases wait for a hold of HOLD_BASE<<(hold_i-1) ticks. A hold code of 0 means no hold.
- R5: In decay, the gain rises by one code every DCY_BASE<<decay_i ticks.
- R6: Each applied step leaves the gain within [8*min_code_i, 8*max_code_i+7].
- R7: With `limiter_i`=1, every valid sample above target lowers the gain by one code in the same cycle and raises `limit_o`. A sample at or below target goes straight to decay with no hold.
- R8: With `gate_en_i`=1 and the last valid sample's magnitude below 2^(gate_thr_i+NZ_SHIFT), decay steps are dropped and `gate_o` is 1.
- R9: With `zc_en_i`=1, a step is applied only at a valid sample whose sign bit differs from the previous valid sample's sign bit. Until then the step stays pending.
- R10: The gain changes only at a valid sample and by at most one code. Requests made between samples collapse into one pending step, and the most recent request wins.
- R11: A sample above target always wins over a decay step in the same cycle. A new attack restarts the hold timer in full when the signal next drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Level control enable |
| limiter_i | input | 1 | 0 level tracking, 1 peak limiting |
| target_i | input | 4 | Target level code |
| hold_i | input | 4 | Hold time code |
| attack_i | input | 4 | Attack step period code |
| decay_i | input | 4 | Decay step period code |
| min_code_i | input | 3 | Lower gain window code |
| max_code_i | input | 3 | Upper gain window code |
| gate_en_i | input | 1 | Noise gate enable |
| gate_thr_i | input | 3 | Noise gate threshold code |
| zc_en_i | input | 1 | Defer steps to a sign change |
| manual_gain_i | input | 6 | Gain used while disabled |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SW | Signed sample |
| tick_i | input | 1 | Slow timer tick |
| gain_o | output | 6 | Amplifier gain code |
| limit_o | output | 1 | Peak limiter is attacking |
| gate_o | output | 1 | Noise gate is holding gain |

## Verification
The hardest state to reach from the ports is a restarted hold. The timer has to be partway through a hold when a single loud sample arrives, and then a quiet sample must start the count again from zero. The stimulus places this loud sample four ticks into an eight-tick hold. It then counts cycles to the first increase, which must cover the whole hold plus one decay period. A step kept pending by the zero-cross rule, with further timer requests piling up behind it, is set up the same way: a run of same-sign loud samples with ticks, then one sample of the opposite sign. A long stretch of random configuration, sample and tick traffic is compared every cycle against a behavioural model, so that attack and decay meet within the same cycle.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W = 6;

  typedef enum logic [1:0] {
    PH_DCY  = 2'd0,
    PH_HOLD = 2'd1,
    PH_ATK  = 2'd2
  } alc_phase_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } alc_step_e;
endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect #(
  parameter int SW       = 16,
  parameter int NZ_SHIFT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [SW-1:0] smp_i,
  input  logic [3:0]    target_i,
  input  logic [2:0]    gate_thr_i,
  input  logic          zc_en_i,
  output logic          over_o,
  output logic          under_o,
  output logic          zc_ok_o,
  output logic          quiet_o
);
  logic [SW:0] smp_x, mag, tgt_lvl, nz_lvl;
  logic        sgn_q, quiet_q, above;

  assign smp_x   = {smp_i[SW-1], smp_i};
  assign mag     = smp_i[SW-1] ? (~smp_x + 1'b1) : smp_x;
  assign tgt_lvl = ({{(SW-3){1'b0}}, target_i} + (SW+1)'(1)) << (SW-5);
  assign nz_lvl  = (SW+1)'(1) << (5'(gate_thr_i) + 5'(NZ_SHIFT));
  assign above   = mag > tgt_lvl;

  assign over_o  = smp_valid_i && above;
  assign under_o = smp_valid_i && !above;
  assign zc_ok_o = !zc_en_i || (smp_i[SW-1] != sgn_q);
  assign quiet_o = quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sgn_q   <= 1'b0;
      quiet_q <= 1'b0;
    end else if (smp_valid_i) begin
      sgn_q   <= smp_i[SW-1];
      quiet_q <= mag < nz_lvl;
    end
  end
endmodule

// File: rtl/alc_timer.sv
module alc_timer
  import alc_pkg::*;
#(
  parameter int ATK_BASE  = 2,
  parameter int DCY_BASE  = 4,
  parameter int HOLD_BASE = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       limiter_i,
  input  logic       over_i,
  input  logic       under_i,
  input  logic       tick_i,
  input  logic       gate_block_i,
  input  logic [3:0] hold_i,
  input  logic [3:0] attack_i,
  input  logic [3:0] decay_i,
  output alc_phase_e phase_o,
  output alc_step_e  req_o
);
  localparam int MAXB = (ATK_BASE > DCY_BASE) ?
                        ((ATK_BASE > HOLD_BASE) ? ATK_BASE : HOLD_BASE) :
                        ((DCY_BASE > HOLD_BASE) ? DCY_BASE : HOLD_BASE);
  localparam int CW = $clog2(MAXB + 1) + 16;

  alc_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CW-1:0] atk_per, dcy_per, hold_per;
  alc_step_e     req;
  logic          moved;

  // every period is a left shift of its base count
  assign atk_per  = CW'(ATK_BASE) << attack_i;
  assign dcy_per  = CW'(DCY_BASE) << decay_i;
  assign hold_per = (hold_i == 4'd0) ? '0 : (CW'(HOLD_BASE) << (hold_i - 4'd1));
  assign cnt_inc  = cnt_q + CW'(1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    req     = STEP_NONE;
    moved   = 1'b0;
    if (!en_i) begin
      phase_d = PH_DCY;
      cnt_d   = '0;
    end else begin
      if (over_i) begin
        if (phase_q != PH_ATK) begin
          phase_d = PH_ATK;
          cnt_d   = '0;
          moved   = 1'b1;
        end
        if (limiter_i) req = STEP_DN;
      end else if (under_i && phase_q == PH_ATK) begin
        phase_d = (limiter_i || hold_i == 4'd0) ? PH_DCY : PH_HOLD;
        cnt_d   = '0;
        moved   = 1'b1;
      end
      if (tick_i && !moved) begin
        case (phase_q)
          PH_ATK: begin
            if (!limiter_i) begin
              if (cnt_inc >= atk_per) begin
                req   = STEP_DN;
                cnt_d = '0;
              end else cnt_d = cnt_inc;
            end
          end
          PH_HOLD: begin
            if (cnt_inc >= hold_per) begin
              phase_d = PH_DCY;
              cnt_d   = '0;
            end else cnt_d = cnt_inc;
          end
          default: begin
            if (cnt_inc >= dcy_per) begin
              cnt_d = '0;
              if (!gate_block_i) req = STEP_UP;
            end else cnt_d = cnt_inc;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DCY;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign req_o   = req;

  // R11
  ovr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && over_i) |=> phase_q == PH_ATK);
  // R5
  up_from_decay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == STEP_UP) |-> phase_q == PH_DCY);
  // R7
  lim_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && limiter_i && under_i && phase_q == PH_ATK) |=> phase_q == PH_DCY);
  // R4
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && under_i && phase_q == PH_ATK && hold_i == 4'd0) |=> phase_q == PH_DCY);
  // R8
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_block_i |-> req_o != STEP_UP);
endmodule

// File: rtl/alc_gain_reg.sv
module alc_gain_reg
  import alc_pkg::*;
#(
  parameter int RESET_GAIN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [GAIN_W-1:0] manual_gain_i,
  input  logic              smp_valid_i,
  input  logic              zc_ok_i,
  input  alc_step_e         req_i,
  input  logic [2:0]        min_code_i,
  input  logic [2:0]        max_code_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic [GAIN_W-1:0] gain_q, lo, hi;
  alc_step_e         pend_q, eff;
  logic              apply;
  logic signed [7:0] nxt, clamped, lo_s, hi_s;

  assign lo    = {min_code_i, 3'b000};
  assign hi    = {max_code_i, 3'b111};
  assign lo_s  = $signed({2'b00, lo});
  assign hi_s  = $signed({2'b00, hi});
  // a fresh request replaces anything still pending
  assign eff   = (req_i != STEP_NONE) ? req_i : pend_q;
  assign apply = en_i && smp_valid_i && zc_ok_i && (eff != STEP_NONE);
  assign nxt   = $signed({2'b00, gain_q}) + ((eff == STEP_UP) ? 8'sd1 : -8'sd1);

  always_comb begin
    clamped = nxt;
    if (clamped > hi_s) clamped = hi_s;
    if (clamped < lo_s) clamped = lo_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= GAIN_W'(RESET_GAIN);
      pend_q <= STEP_NONE;
    end else if (!en_i) begin
      gain_q <= manual_gain_i;
      pend_q <= STEP_NONE;
    end else if (apply) begin
      gain_q <= clamped[GAIN_W-1:0];
      pend_q <= STEP_NONE;
    end else if (req_i != STEP_NONE) begin
      pend_q <= req_i;
    end
  end

  assign gain_o = gain_q;

  // R10
  sample_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(smp_valid_i)) |-> $stable(gain_q));
  // R10
  one_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(gain_q) >= $past(lo) && $past(gain_q) <= $past(hi)) |->
    (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 6'd1 ||
     gain_q == $past(gain_q) - 6'd1));
  // R6
  window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(apply) && $past(min_code_i <= max_code_i)) |->
    (gain_q >= $past(lo) && gain_q <= $past(hi)));
  // R9
  zc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(zc_ok_i)) |-> $stable(gain_q));
endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
  import alc_pkg::*;
#(
  parameter int SW         = 16,
  parameter int ATK_BASE   = 2,
  parameter int DCY_BASE   = 4,
  parameter int HOLD_BASE  = 2,
  parameter int NZ_SHIFT   = 4,
  parameter int RESET_GAIN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          limiter_i,
  input  logic [3:0]    target_i,
  input  logic [3:0]    hold_i,
  input  logic [3:0]    attack_i,
  input  logic [3:0]    decay_i,
  input  logic [2:0]    min_code_i,
  input  logic [2:0]    max_code_i,
  input  logic          gate_en_i,
  input  logic [2:0]    gate_thr_i,
  input  logic          zc_en_i,
  input  logic [5:0]    manual_gain_i,
  input  logic          smp_valid_i,
  input  logic [SW-1:0] smp_i,
  input  logic          tick_i,
  output logic [5:0]    gain_o,
  output logic          limit_o,
  output logic          gate_o
);
  logic        over, under, zc_ok, quiet;
  alc_phase_e  phase;
  alc_step_e   req;
  logic [5:0]  gain_q;

  alc_level_detect #(.SW(SW), .NZ_SHIFT(NZ_SHIFT)) u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .smp_i       (smp_i),
    .target_i    (target_i),
    .gate_thr_i  (gate_thr_i),
    .zc_en_i     (zc_en_i),
    .over_o      (over),
    .under_o     (under),
    .zc_ok_o     (zc_ok),
    .quiet_o     (quiet)
  );

  alc_timer #(.ATK_BASE(ATK_BASE), .DCY_BASE(DCY_BASE), .HOLD_BASE(HOLD_BASE)) u_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .limiter_i    (limiter_i),
    .over_i       (over),
    .under_i      (under),
    .tick_i       (tick_i),
    .gate_block_i (gate_en_i && quiet),
    .hold_i       (hold_i),
    .attack_i     (attack_i),
    .decay_i      (decay_i),
    .phase_o      (phase),
    .req_o        (req)
  );

  alc_gain_reg #(.RESET_GAIN(RESET_GAIN)) u_gain (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .manual_gain_i (manual_gain_i),
    .smp_valid_i   (smp_valid_i),
    .zc_ok_i       (zc_ok),
    .req_i         (req),
    .min_code_i    (min_code_i),
    .max_code_i    (max_code_i),
    .gain_o        (gain_q)
  );

  assign gain_o  = en_i ? gain_q : manual_gain_i;
  assign limit_o = en_i && limiter_i && (phase == PH_ATK);
  assign gate_o  = en_i && gate_en_i && quiet;
endmodule

// File: tb/alc_gain_engine_bench.sv
`timescale 1ns/100ps
module alc_gain_engine_bench;
  localparam int SW = 16, ATK_B = 2, DCY_B = 4, HOLD_B = 2, NZS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, lim = 1'b0, gen = 1'b0, zc = 1'b0;
  logic [3:0] tgt = 4'd7, hold = 4'd0, atk = 4'd0, dcy = 4'd0;
  logic [2:0] minc = 3'd0, maxc = 3'd7, gthr = 3'd0;
  logic [5:0] manual = 6'd50;
  logic smp_valid = 1'b0, tick = 1'b0;
  logic signed [SW-1:0] smp = '0;
  logic [5:0] gain_o;
  logic limit_o, gate_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string tag = "R2";

  always #2.5 clk = ~clk;

  alc_gain_engine #(.SW(SW), .ATK_BASE(ATK_B), .DCY_BASE(DCY_B), .HOLD_BASE(HOLD_B),
                    .NZ_SHIFT(NZS), .RESET_GAIN(16)) u_alc_gain_engine (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .limiter_i(lim), .target_i(tgt),
    .hold_i(hold), .attack_i(atk), .decay_i(dcy), .min_code_i(minc), .max_code_i(maxc),
    .gate_en_i(gen), .gate_thr_i(gthr), .zc_en_i(zc), .manual_gain_i(manual),
    .smp_valid_i(smp_valid), .smp_i(smp), .tick_i(tick),
    .gain_o(gain_o), .limit_o(limit_o), .gate_o(gate_o));

  // behavioural reference: m_ph 0 decay, 1 hold, 2 attack
  int m_gain, m_ph, m_cnt, m_pend;
  bit m_quiet, m_sgn;

  always @(posedge clk or negedge rst_n) begin
    int sv, mag, reqd, eff, g, hp, lo, hi;
    bit ov, un, zok, moved;
    if (!rst_n) begin
      m_gain = 16; m_ph = 0; m_cnt = 0; m_pend = 0; m_quiet = 0; m_sgn = 0;
    end else begin
      sv  = int'(smp);
      mag = (sv < 0) ? -sv : sv;
      ov  = smp_valid && (mag > (int'(tgt) + 1) * (1 << (SW - 5)));
      un  = smp_valid && !ov;
      zok = !zc || ((sv < 0) != m_sgn);
      reqd = 0;
      lo = int'(minc) * 8;
      hi = int'(maxc) * 8 + 7;
      hp = (hold == 0) ? 0 : (HOLD_B << (int'(hold) - 1));
      if (!en) begin
        m_ph = 0; m_cnt = 0; m_pend = 0; m_gain = int'(manual);
      end else begin
        moved = 0;
        if (ov) begin
          if (m_ph != 2) begin m_ph = 2; m_cnt = 0; moved = 1; end
          if (lim) reqd = -1;
        end else if (un && m_ph == 2) begin
          m_ph = (lim || hold == 0) ? 0 : 1; m_cnt = 0; moved = 1;
        end
        if (tick && !moved) begin
          if (m_ph == 2) begin
            if (!lim) begin
              if (m_cnt + 1 >= (ATK_B << atk)) begin reqd = -1; m_cnt = 0; end
              else m_cnt++;
            end
          end else if (m_ph == 1) begin
            if (m_cnt + 1 >= hp) begin m_ph = 0; m_cnt = 0; end
            else m_cnt++;
          end else begin
            if (m_cnt + 1 >= (DCY_B << dcy)) begin
              m_cnt = 0;
              if (!(gen && m_quiet)) reqd = 1;
            end else m_cnt++;
          end
        end
        eff = (reqd != 0) ? reqd : m_pend;
        if (smp_valid && zok && eff != 0) begin
          g = m_gain + eff;
          if (g > hi) g = hi;
          if (g < lo) g = lo;
          m_gain = g; m_pend = 0;
        end else if (reqd != 0) m_pend = reqd;
      end
      if (smp_valid) begin
        m_quiet = mag < (1 << (int'(gthr) + NZS));
        m_sgn   = sv < 0;
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    int eg;
    bit el, eq;
    if (rst_n && !done) begin
      eg = en ? m_gain : int'(manual);
      el = en && lim && (m_ph == 2);
      eq = en && gen && m_quiet;
      n_cmp++;
      if (int'(gain_o) != eg || limit_o != el || gate_o != eq) begin
        n_bad++;
        $display("FAIL %s model: gain_o=%0d exp %0d limit_o=%0b exp %0b gate_o=%0b exp %0b",
                 tag, gain_o, eg, limit_o, el, gate_o, eq);
      end
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic step(input bit v, input int s, input bit t);
    @(negedge clk);
    #1;
    smp_valid = v;
    smp = SW'(s);
    tick = t;
  endtask

  task automatic load(input int g);
    en = 1'b0;
    manual = 6'(g);
    step(0, 0, 0);
    en = 1'b1;
  endtask

  task automatic spacing(input int s, output int d);
    int prev, c1;
    c1 = -1; d = -1; prev = int'(gain_o);
    for (int k = 1; k <= 300; k++) begin
      step(1, s, 1);
      if (int'(gain_o) != prev) begin
        prev = int'(gain_o);
        if (c1 < 0) c1 = k;
        else begin d = k - c1; break; end
      end
    end
  endtask

  task automatic first_move(input int s, output int k);
    int g0;
    g0 = -1; k = -1;
    for (int kk = 1; kk <= 300; kk++) begin
      step(1, s, 1);
      if (kk == 1) g0 = int'(gain_o);
      else if (int'(gain_o) != g0) begin k = kk; break; end
    end
  endtask

  task automatic fin();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      fin();
    end
  end

  initial begin
    int d, k;
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0);
    // R2 reset state
    chk("R2 gain", int'(gain_o), 16);
    chk("R2 limit", int'(limit_o), 0);
    chk("R2 gate", int'(gate_o), 0);

    // R1 disabled follows manual
    tag = "R1"; en = 1'b0; lim = 1'b1; manual = 6'd33;
    repeat (20) step(1, 20000, 1);
    chk("R1 gain", int'(gain_o), 33);
    chk("R1 limit", int'(limit_o), 0);
    lim = 1'b0;

    // R3 attack spacing per code
    tag = "R3";
    for (int a = 0; a < 4; a++) begin
      atk = 4'(a);
      load(63);
      spacing(20000, d);
      chk($sformatf("R3 attack spacing code %0d", a), d, ATK_B << a);
    end
    chk("R3 attack lowered", int'(gain_o < 6'd63), 1);

    // R5 decay spacing per code
    tag = "R5"; atk = 4'd0;
    for (int c = 0; c < 4; c++) begin
      dcy = 4'(c);
      load(0);
      spacing(1000, d);
      chk($sformatf("R5 decay spacing code %0d", c), d, DCY_B << c);
    end

    // R4 hold then decay
    tag = "R4"; dcy = 4'd0; hold = 4'd3;
    load(40);
    repeat (3) step(1, 20000, 1);
    first_move(1000, k);
    chk("R4 hold 3 first rise", k, (HOLD_B << 2) + DCY_B + 2);
    hold = 4'd0;
    repeat (3) step(1, 20000, 1);
    first_move(1000, k);
    chk("R4 hold 0 first rise", k, DCY_B + 2);

    // R11 new attack restarts the hold
    tag = "R11"; hold = 4'd3;
    repeat (3) step(1, 20000, 1);
    repeat (4) step(1, 1000, 1);
    step(1, 20000, 0);
    first_move(1000, k);
    chk("R11 hold restarted", k, (HOLD_B << 2) + DCY_B + 2);

    // R6 clamp window
    tag = "R6"; hold = 4'd0; minc = 3'd3; maxc = 3'd4;
    load(30);
    repeat (100) step(1, 20000, 1);
    chk("R6 floor", int'(gain_o), 24);
    repeat (200) step(1, 1000, 1);
    chk("R6 ceiling", int'(gain_o), 39);
    minc = 3'd0; maxc = 3'd7;

    // R7 peak limiter
    tag = "R7"; lim = 1'b1; hold = 4'd5;
    load(40);
    repeat (3) step(1, 20000, 0);
    step(0, 0, 0);
    chk("R7 per-sample steps", int'(gain_o), 37);
    chk("R7 limit flag", int'(limit_o), 1);
    first_move(1000, k);
    chk("R7 no hold", k, DCY_B + 2);
    chk("R7 limit released", int'(limit_o), 0);
    lim = 1'b0; hold = 4'd0;

    // R8 noise gate
    tag = "R8"; gen = 1'b1; gthr = 3'd2;
    load(20);
    repeat (60) step(1, 10, 1);
    chk("R8 gain frozen", int'(gain_o), 20);
    chk("R8 gate flag", int'(gate_o), 1);
    repeat (20) step(1, 1000, 1);
    chk("R8 rises after gate", int'(gain_o > 6'd20), 1);
    chk("R8 gate cleared", int'(gate_o), 0);
    gen = 1'b0;

    // R9 zero cross deferral
    tag = "R9"; zc = 1'b1;
    load(40);
    step(1, -20000, 0);
    repeat (10) step(1, 20000, 1);
    chk("R9 held without sign change", int'(gain_o), 40);
    step(1, -20000, 0);
    step(0, 0, 0);
    chk("R9 applied at sign change", int'(gain_o), 39);
    zc = 1'b0;

    // R10 steps only at samples, one code
    tag = "R10";
    load(40);
    step(1, 1000, 0);
    repeat (30) step(0, 0, 1);
    chk("R10 no sample no change", int'(gain_o), 40);
    step(1, 1000, 0);
    step(0, 0, 0);
    chk("R10 single step", int'(gain_o), 41);

    // R11 mixed random traffic against the model
    tag = "R11";
    lf = 32'hACE1_2025;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (i % 150 == 0) begin
        en = lf[2] | lf[3] | lf[4];
        lim = lf[6]; tgt = lf[10:7]; hold = {2'b00, lf[12:11]};
        atk = {2'b00, lf[14:13]}; dcy = {2'b00, lf[16:15]};
        minc = {1'b0, lf[18:17]}; maxc = {1'b1, lf[20:19]};
        gen = lf[21]; gthr = lf[24:22]; zc = lf[25]; manual = lf[31:26];
      end
      step(lf[0] | lf[1], int'($signed(lf[31:16])) >>> (lf[5] ? 0 : 6), lf[5] | lf[9]);
    end
    step(0, 0, 0);
    fin();
  end
endmodule